// File: doc/BRIEF.md
# Flash Completion Status Poller

This block decides when an external parallel flash device has finished an internal program or erase operation. It does not drive the flash bus itself. It asks a separate bus engine for status reads through a request/acknowledge handshake and judges each returned byte. It then reports completion with a one-cycle done pulse. Two flags travel with that pulse: one says the iteration cap stopped the loop, the other says the poll took an unusually long time.

There are two ways to judge completion. In toggle mode the device flips bit 6 on every read while it is busy. The poller takes one priming read, then keeps reading until bit 6 of a read equals bit 6 of the read before it. Between these reads it waits a programmable number of microseconds, converted to clock cycles by a parameter. A gap of zero gives fast polling; a gap of about 8 ms suits erase operations. In data-poll mode the device shows the complement of the written bit 7 until the write completes. The poller reads back to back until bit 7 equals bit 7 of the expected byte.

Top module: `flash_busy_poller`

## Requirements
- R1: After reset, `busy_o`, `rd_req_o`, `done_o`, `timeout_o` and `excessive_o` are all low.
- R2: With `mode_i` = 0 (toggle), the first read only records bit 6 (mask 0x40). Each later read is a compare read. The operation completes on the first compare read whose bit 6 equals bit 6 of the read just before it. All other bits are ignored.
- R3: With `mode_i` = 1 (data poll), every read is a compare read. The operation completes on the first read whose bit 7 (mask 0x80) equals bit 7 of `expect_i`. All other bits are ignored.
- R4: In toggle mode, `rd_req_o` stays low for exactly `gap_us_i * CYC_PER_US` cycles after each accepted read that does not end the operation, and then rises again. In data-poll mode the next request follows with no gap.
- R5: `rd_req_o` stays high until a cycle in which `rd_ack_i` is high. `rd_data_i` is taken in that cycle, and a wait of any length before the acknowledge does not change the result.
- R6: If `ITER_CAP` compare reads have been made without completion, the loop stops, and `timeout_o` is raised together with `done_o`. A match on the `ITER_CAP`-th compare read counts as completion, without timeout.
- R7: `excessive_o` is raised together with `done_o` when the number of compare reads made exceeds `EXCESS_LIM`.
- R8: `done_o` is high for exactly one cycle: the cycle after the acknowledge of the final read. In that cycle `busy_o` and `rd_req_o` are low. `timeout_o` and `excessive_o` are high only in a `done_o` cycle.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The running operation keeps its read count and its timing.
- R10: `mode_i`, `expect_i` and `gap_us_i` are captured in the cycle a start is accepted. Later changes to them do not affect the running operation, and `busy_o` rises only after an accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only while idle |
| mode_i | input | 1 | 0 = toggle-bit mode, 1 = data-poll mode |
| expect_i | input | 8 | Byte being written; only bit 7 is used |
| gap_us_i | input | GAP_W | Wait before each toggle-mode compare read, in microseconds |
| rd_req_o | output | 1 | Status read request to the bus engine |
| rd_ack_i | input | 1 | Read acknowledge; `rd_data_i` is valid with it |
| rd_data_i | input | 8 | Byte read from the flash |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | With `done_o`: the cap ended the loop |
| excessive_o | output | 1 | With `done_o`: compare reads exceeded `EXCESS_LIM` |

## Verification
A wrong internal state shows at the ports in one of three ways. An extra or missing read shows within one read as a changed acknowledge count. A wrongly latched previous bit or expected bit moves the done pulse by at least one read. A wrong gap count moves the next `rd_req_o` rise by at least one cycle, which the spacing measurement reports at the very next read. A wrong iteration count shows only at the end of the operation, as a wrong `timeout_o` or `excessive_o` value or a wrong total number of reads. For that reason the sweep crosses the cap and the excessive threshold one settle point at a time.

// File: rtl/poll_pkg.sv
// Shared types for the flash completion status poller.
// Assumes: one poll runs at a time; the state encodings are internal only.
package poll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_GAP   = 2'd2,
        ST_READ  = 2'd3
    } poll_state_t;

    typedef enum logic {
        MODE_TOGGLE = 1'b0,
        MODE_DATA   = 1'b1
    } poll_mode_t;

endpackage

// File: rtl/poll_gap_timer.sv
// Down-counter that times the wait before a toggle-mode compare read.
// Assumes: it is loaded only with a nonzero value; last_o marks the final wait cycle.
module poll_gap_timer #(
    parameter int unsigned DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DLY_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             last_o
);
    logic [DLY_W-1:0] remain_q;

    // load a new wait, or count down while the wait state is active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load_i) begin
            remain_q <= load_val_i;
        end else if (run_i && (remain_q != '0)) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // last wait cycle when a single count remains
    always_comb last_o = (remain_q == DLY_W'(1));

endmodule

// File: rtl/poll_iter_counter.sv
// Counts compare reads in one poll and looks one read ahead at the cap and the warning limit.
// Assumes: cleared on every accepted start; never counts past the cap because the poll stops there.
module poll_iter_counter #(
    parameter int unsigned ITER_CAP   = 32'h0FFF_FFFF,
    parameter int unsigned EXCESS_LIM = 32'h0010_0000,
    localparam int unsigned CNT_W     = $clog2(ITER_CAP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic cap_next_o,
    output logic over_next_o
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W:0]   count_nx;

    // clear at start, step on each compare read
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            count_q <= '0;
        end else if (inc_i) begin
            count_q <= count_nx[CNT_W-1:0];
        end
    end

    // count this read would reach, and its comparisons with the cap and the limit
    always_comb begin
        count_nx    = {1'b0, count_q} + 1'b1;
        cap_next_o  = (count_nx >= (CNT_W+1)'(ITER_CAP));
        over_next_o = (count_nx >  (CNT_W+1)'(EXCESS_LIM));
    end

endmodule

// File: rtl/poll_bit_judge.sv
// Judges one status byte: toggle bit stable, or polled bit equal to the expected bit.
// Assumes: prev6_i holds bit 6 of the previous read in toggle mode.
module poll_bit_judge
    import poll_pkg::*;
(
    input  poll_mode_t mode_i,
    input  logic [7:0] rd_data_i,
    input  logic       prev6_i,
    input  logic       exp7_i,
    output logic       settled_o,
    output logic       bit6_o
);
    localparam logic [7:0] TOGGLE_MASK = 8'h40;
    localparam logic [7:0] POLL_MASK   = 8'h80;

    // select the status bit for the mode and compare it with its reference
    always_comb begin
        bit6_o = |(rd_data_i & TOGGLE_MASK);
        if (mode_i == MODE_TOGGLE) begin
            settled_o = (bit6_o == prev6_i);
        end else begin
            settled_o = ((|(rd_data_i & POLL_MASK)) == exp7_i);
        end
    end

endmodule

// File: rtl/flash_busy_poller.sv
// Top of the flash completion status poller: sequences status reads through a
// request/acknowledge port and reports completion, cap timeout and excessive polling.
// Assumes: the bus engine holds rd_data_i valid in the cycle rd_ack_i is high.
module flash_busy_poller
    import poll_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 50,
    parameter int unsigned GAP_W      = 14,
    parameter int unsigned ITER_CAP   = 32'h0FFF_FFFF,
    parameter int unsigned EXCESS_LIM = 32'h0010_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic [7:0]       expect_i,
    input  logic [GAP_W-1:0] gap_us_i,
    output logic             rd_req_o,
    input  logic             rd_ack_i,
    input  logic [7:0]       rd_data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             timeout_o,
    output logic             excessive_o
);
    localparam int unsigned CYC_W = $clog2(CYC_PER_US + 1);
    localparam int unsigned DLY_W = GAP_W + CYC_W;

    poll_state_t      state_q, state_d;
    poll_mode_t       mode_q;
    logic             exp7_q;
    logic             prev6_q;
    logic [DLY_W-1:0] dly_q;
    logic             done_q, tout_q, exc_q;
    logic             done_d, tout_d, exc_d;

    logic accept, take, settled, bit6, cap_next, over_next, to_gap, gap_last;

    // a start is taken only when idle; a read is taken on acknowledge of a request
    always_comb begin
        accept   = start_i && (state_q == ST_IDLE);
        rd_req_o = (state_q == ST_PRIME) || (state_q == ST_READ);
        take     = rd_req_o && rd_ack_i;
    end

    poll_bit_judge u_judge (
        .mode_i    (mode_q),
        .rd_data_i (rd_data_i),
        .prev6_i   (prev6_q),
        .exp7_i    (exp7_q),
        .settled_o (settled),
        .bit6_o    (bit6)
    );

    poll_iter_counter #(
        .ITER_CAP   (ITER_CAP),
        .EXCESS_LIM (EXCESS_LIM)
    ) u_iter (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (accept),
        .inc_i       (take && (state_q == ST_READ)),
        .cap_next_o  (cap_next),
        .over_next_o (over_next)
    );

    // a toggle-mode read that does not end the poll leads to the next wait
    always_comb begin
        to_gap = take && (mode_q == MODE_TOGGLE) &&
                 ((state_q == ST_PRIME) ||
                  ((state_q == ST_READ) && !settled && !cap_next));
    end

    poll_gap_timer #(
        .DLY_W (DLY_W)
    ) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (to_gap && (dly_q != '0)),
        .load_val_i (dly_q),
        .run_i      (state_q == ST_GAP),
        .last_o     (gap_last)
    );

    // next state and end-of-poll flags
    always_comb begin
        state_d = state_q;
        done_d  = 1'b0;
        tout_d  = 1'b0;
        exc_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (poll_mode_t'(mode_i) == MODE_TOGGLE) ? ST_PRIME : ST_READ;
                end
            end
            ST_PRIME: begin
                if (to_gap) begin
                    state_d = (dly_q == '0) ? ST_READ : ST_GAP;
                end
            end
            ST_GAP: begin
                if (gap_last) begin
                    state_d = ST_READ;
                end
            end
            ST_READ: begin
                if (take && (settled || cap_next)) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                    tout_d  = !settled;
                    exc_d   = over_next;
                end else if (to_gap) begin
                    state_d = (dly_q == '0) ? ST_READ : ST_GAP;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            tout_q  <= 1'b0;
            exc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
            tout_q  <= tout_d;
            exc_q   <= exc_d;
        end
    end

    // capture the poll setup when a start is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_TOGGLE;
            exp7_q <= 1'b0;
            dly_q  <= '0;
        end else if (accept) begin
            mode_q <= poll_mode_t'(mode_i);
            exp7_q <= expect_i[7];
            dly_q  <= DLY_W'(gap_us_i) * DLY_W'(CYC_PER_US);
        end
    end

    // remember bit 6 of every accepted read for the next toggle comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev6_q <= 1'b0;
        end else if (take) begin
            prev6_q <= bit6;
        end
    end

    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        done_o      = done_q;
        timeout_o   = tout_q;
        excessive_o = exc_q;
    end

endmodule

// File: rtl/poll_checker.sv
// Port-level assertions for flash_busy_poller, attached by bind.
// Assumes: the same parameter values as the bound instance.
module poll_checker #(
    parameter int unsigned CYC_PER_US = 50,
    parameter int unsigned GAP_W      = 14,
    parameter int unsigned ITER_CAP   = 32'h0FFF_FFFF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [GAP_W-1:0] gap_us_i,
    input logic             busy_o,
    input logic             rd_req_o,
    input logic             rd_ack_i,
    input logic             done_o,
    input logic             timeout_o,
    input logic             excessive_o
);
    localparam int unsigned CYC_W = $clog2(CYC_PER_US + 1);
    localparam int unsigned DLY_W = GAP_W + CYC_W;
    localparam int unsigned CNT_W = $clog2(ITER_CAP + 1);

    logic [DLY_W-1:0] gap_lat;
    logic [DLY_W:0]   low_cnt;
    logic [CNT_W:0]   ack_cnt;
    logic             acc;

    always_comb acc = start_i && !busy_o;

    // gap in cycles captured at each accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) gap_lat <= '0;
        else if (acc) gap_lat <= DLY_W'(gap_us_i) * DLY_W'(CYC_PER_US);
    end

    // cycles of a busy poll spent without a request
    always_ff @(posedge clk) begin
        if (!rst_n || acc || rd_req_o) low_cnt <= '0;
        else if (busy_o) low_cnt <= low_cnt + 1'b1;
    end

    // acknowledged reads in the current poll
    always_ff @(posedge clk) begin
        if (!rst_n || acc) ack_cnt <= '0;
        else if (rd_req_o && rd_ack_i) ack_cnt <= ack_cnt + 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !busy_o && !done_o);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);
    // R8
    flags_need_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o || excessive_o) |-> done_o);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !rd_req_o));
    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> rd_req_o);
    // R4
    gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_req_o) && $past(busy_o)) |-> (low_cnt == (DLY_W+1)'(gap_lat)));
    // R6
    read_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i) |-> (ack_cnt <= (CNT_W+1)'(ITER_CAP)));
    // R10
    busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

endmodule

bind flash_busy_poller poll_checker #(
    .CYC_PER_US (CYC_PER_US),
    .GAP_W      (GAP_W),
    .ITER_CAP   (ITER_CAP)
) u_poll_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .gap_us_i    (gap_us_i),
    .busy_o      (busy_o),
    .rd_req_o    (rd_req_o),
    .rd_ack_i    (rd_ack_i),
    .done_o      (done_o),
    .timeout_o   (timeout_o),
    .excessive_o (excessive_o)
);

// File: tb/tb_flash_busy_poller.sv
module tb_flash_busy_poller;
    localparam int CLK_PERIOD = 10;
    localparam int CYC  = 3;
    localparam int GW   = 4;
    localparam int CAP  = 12;
    localparam int EXC  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [7:0]    expect_i = '0;
    logic [GW-1:0] gap_us_i = '0;
    logic          rd_ack_i = 1'b0;
    logic [7:0]    rd_data_i = '0;
    logic          rd_req_o, busy_o, done_o, timeout_o, excessive_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_busy_poller #(
        .CYC_PER_US (CYC),
        .GAP_W      (GW),
        .ITER_CAP   (CAP),
        .EXCESS_LIM (EXC)
    ) dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .mode_i (mode_i),
        .expect_i (expect_i), .gap_us_i (gap_us_i), .rd_req_o (rd_req_o),
        .rd_ack_i (rd_ack_i), .rd_data_i (rd_data_i), .busy_o (busy_o),
        .done_o (done_o), .timeout_o (timeout_o), .excessive_o (excessive_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // status byte for read j: busy pattern up to read s, settled after it
    function automatic logic [7:0] rd_val(input bit md, input logic [7:0] ex, input int s, input int j);
        logic [7:0] v;
        v = 8'((j * 53) + 17);
        if (!md) v[6] = (j <= s) ? j[0] : s[0];
        else     v[7] = (j >= s) ? ex[7] : ~ex[7];
        return v;
    endfunction

    task automatic run_op(input bit md, input logic [7:0] ex, input int g,
                          input int s, input int lat, input bit poke);
        int  j = 0;
        int  cyc = 0;
        int  last_ack = 0;
        int  bad_sp = 0;
        int  wcnt = 0;
        bit  fin = 0;
        bit  tmo = 0;
        bit  exc = 0;
        bit  idle_ok = 0;
        int  cmp, exp_reads, exp_sp;
        cmp       = (s + 1 > CAP) ? CAP : s + 1;
        exp_reads = cmp + (md ? 0 : 1);
        exp_sp    = md ? 1 : g * CYC + 1;

        @(negedge clk);
        start_i = 1'b1; mode_i = md; expect_i = ex; gap_us_i = GW'(g);
        while (!fin && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            // R10: setup inputs change after acceptance
            mode_i = ~md; expect_i = ~ex; gap_us_i = GW'(g + 1);
            start_i = (poke && cyc == 3);
            if (done_o) begin
                fin = 1; tmo = timeout_o; exc = excessive_o;
                idle_ok = !busy_o && !rd_req_o;
                rd_ack_i = 1'b0;
            end else if (rd_req_o) begin
                if (wcnt == lat) begin
                    rd_ack_i = 1'b1;
                    rd_data_i = rd_val(md, ex, s, j);
                    if (j >= 1 && lat == 0 && !poke && (cyc - last_ack) != exp_sp) bad_sp++;
                    last_ack = cyc;
                    j++;
                    wcnt = 0;
                end else begin
                    rd_ack_i = 1'b0;
                    wcnt++;
                end
            end else begin
                rd_ack_i = 1'b0;
                wcnt = 0;
            end
        end
        start_i = 1'b0;
        check(fin, "R8 done seen", fin, 1);
        check(idle_ok, "R8 idle at done", idle_ok, 1);
        if (md) check(j == exp_reads, "R3 data-poll read count", j, exp_reads);
        else    check(j == exp_reads, "R2 toggle read count", j, exp_reads);
        check(tmo == (s + 1 > CAP), "R6 timeout flag", tmo, int'(s + 1 > CAP));
        check(exc == (cmp > EXC), "R7 excessive flag", exc, int'(cmp > EXC));
        if (lat == 0 && !poke) check(bad_sp == 0, "R4 read spacing", bad_sp, 0);
        if (lat > 0) check(j == exp_reads, "R5 waited handshake", j, exp_reads);
        if (poke) check(j == exp_reads, "R9 start while busy ignored", j, exp_reads);
        @(negedge clk);
        check(!done_o && !timeout_o && !excessive_o, "R8 single-cycle done", done_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet in and after reset
        check(!busy_o && !rd_req_o && !done_o && !timeout_o && !excessive_o,
              "R1 reset state", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !rd_req_o && !done_o, "R1 idle after reset", busy_o, 0);
        for (int s = 0; s < 14; s++)
            for (int g = 0; g < 3; g++)
                for (int lat = 0; lat < 2; lat++)
                    run_op(1'b0, 8'h00, g, s, lat, lat == 1);
        for (int s = 0; s < 14; s++)
            for (int e = 0; e < 4; e++)
                for (int lat = 0; lat < 2; lat++)
                    run_op(1'b1, (e == 0) ? 8'h00 : (e == 1) ? 8'h80 : (e == 2) ? 8'h7F : 8'hFF,
                           2, s, lat, lat == 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule